// File: doc/BRIEF.md
# Windowed configuration register access bridge

This block gives a host a way to reach a bank of configuration registers that sits behind a narrow downstream port. The host sees two 32-bit windows on a word-addressed slave port with per-byte enables: a data window and an address/control window. The control word carries the double-word register address, the function selectors and the transfer direction. Storing into its most significant byte starts one 32-bit transfer on the downstream request/acknowledge port. For a write, software fills the data window first. For a read, the returned value lands in the data window when the transfer completes. Software polls a read-only completion flag in the top bit of the control word to learn when the transfer has finished. A second read-only flag shows whether a warm reset is under way.

The sequencer has two states. ST_IDLE moves to ST_BUSY on a launch, which is a control-window write whose byte enables include lane 3 while no warm reset is active. ST_BUSY moves back to ST_IDLE either on the downstream acknowledge or when a warm reset starts, which drops the transfer. Without either event it stays in ST_BUSY. The completion flag reads 1 exactly when the sequencer is in ST_IDLE.

Top module: `cfgwin_bridge`

## Requirements
- R1: The data window is at word address WIN_BASE and the control window at WIN_BASE+1. Byte lane 0 is bits 7:0. A read strobe returns data on `h_rdata` on the next clock edge. Any other address reads as zero and ignores writes.
- R2: The control word fields drive the downstream port while a transfer is pending, as follows. Bits 11:2 drive `c_addr`. Bit 0 drives `c_vsec` and bit 1 drives `c_shadow`. Bits 16:14 drive `c_pf`, bit 17 drives `c_vf_en` and bits 28:18 drive `c_vf`. Bit 30 drives `c_we`, where 1 means write. The data window drives `c_wdata`.
- R3: In ST_IDLE with no warm reset, a control write whose enables cover lane 3 starts exactly one downstream transfer. From the next edge, `c_req` is 1 and control bit 31 reads 0.
- R4: `c_req` stays high until `c_ack`. On the cycle after the acknowledge, `c_req` is 0 and control bit 31 reads 1.
- R5: An acknowledged read transfer loads `c_rdata` into the data window. An acknowledged write transfer leaves the data window unchanged.
- R6: While a transfer is pending, writes to either window are ignored, including a second launch. The request fields stay stable until the acknowledge.
- R7: While `warm_rst` is high, `c_req` is 0, no new transfer starts, and control bit 29 reads 0. A pending transfer is dropped and bit 31 reads 1. With `warm_rst` low, bit 29 reads 1.
- R8: Writes to control bits 31 and 29 have no effect. Reserved bits 13:12 store and read back what was written.
- R9: A write updates only the byte lanes whose enable bit is set.
- R10: After reset the data window is 0, the control fields are 0, bit 31 reads 1 and `c_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| warm_rst | input | 1 | High while a warm reset is in progress |
| h_addr | input | SAW | Slave word address |
| h_be | input | 4 | Slave byte enables |
| h_wr | input | 1 | Slave write strobe |
| h_wdata | input | 32 | Slave write data |
| h_rd | input | 1 | Slave read strobe |
| h_rdata | output | 32 | Slave read data, valid one cycle after `h_rd` |
| c_req | output | 1 | Downstream transfer request |
| c_we | output | 1 | Downstream direction, 1 = write |
| c_addr | output | 10 | Downstream double-word address |
| c_vf | output | 11 | Virtual function number |
| c_vf_en | output | 1 | Virtual function access enable |
| c_pf | output | 3 | Physical function number |
| c_shadow | output | 1 | Alternate register space select |
| c_vsec | output | 1 | Vendor-specific capability space select |
| c_wdata | output | 32 | Downstream write data |
| c_ack | input | 1 | Downstream acknowledge |
| c_rdata | input | 32 | Downstream read data, valid with `c_ack` |

## Verification
The assertions assume that the downstream side raises `c_ack` only while `c_req` is high and keeps `c_rdata` valid in that same cycle. They also assume that `warm_rst` changes only between clock edges. The stimulus drives every input on the falling edge, pulses the acknowledge for one cycle only after it has seen the request, and raises the warm reset only on a cycle where no acknowledge is driven.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int DW       = 32;
    localparam int LANES    = DW / 8;

    localparam int B_DONE   = 31;
    localparam int B_DIR    = 30;
    localparam int B_WARM   = 29;
    localparam int VF_HI    = 28;
    localparam int VF_LO    = 18;
    localparam int B_VFEN   = 17;
    localparam int PF_HI    = 16;
    localparam int PF_LO    = 14;
    localparam int DA_HI    = 11;
    localparam int DA_LO    = 2;
    localparam int B_SHADOW = 1;
    localparam int B_VSEC   = 0;

    localparam int VF_W     = VF_HI - VF_LO + 1;
    localparam int PF_W     = PF_HI - PF_LO + 1;
    localparam int DA_W     = DA_HI - DA_LO + 1;

    localparam logic [DW-1:0] CTRL_WMASK =
        ~((32'(1) << B_DONE) | (32'(1) << B_WARM));

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
    import cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             sel_data,
    input  logic             sel_ctrl,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic             cap_en,
    input  logic [DW-1:0]    cap_data,
    output logic [DW-1:0]    data_q,
    output logic [DW-1:0]    ctrl_q
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[ln*8 +: 8] <= '0;
            end else if (cap_en) begin
                data_q[ln*8 +: 8] <= cap_data[ln*8 +: 8];
            end else if (wr_ok && sel_data && be[ln]) begin
                data_q[ln*8 +: 8] <= wdata[ln*8 +: 8];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[ln*8 +: 8] <= '0;
            end else if (wr_ok && sel_ctrl && be[ln]) begin
                ctrl_q[ln*8 +: 8] <= wdata[ln*8 +: 8] & CTRL_WMASK[ln*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
    import cfgwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic warm,
    input  logic ack,
    input  logic dir_we,
    output logic busy,
    output logic done,
    output logic req,
    output logic capture
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch && !warm) state_d = ST_BUSY;
            ST_BUSY: if (warm || ack)     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        req     = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: done = 1'b1;
            ST_BUSY: begin
                busy    = 1'b1;
                req     = !warm;
                capture = !warm && ack && !dir_we;
            end
            default: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
    import cfgwin_pkg::*;
#(
    parameter int SAW      = 3,
    parameter int WIN_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic [SAW-1:0]    h_addr,
    input  logic [3:0]        h_be,
    input  logic              h_wr,
    input  logic [31:0]       h_wdata,
    input  logic              h_rd,
    output logic [31:0]       h_rdata,
    output logic              c_req,
    output logic              c_we,
    output logic [9:0]        c_addr,
    output logic [10:0]       c_vf,
    output logic              c_vf_en,
    output logic [2:0]        c_pf,
    output logic              c_shadow,
    output logic              c_vsec,
    output logic [31:0]       c_wdata,
    input  logic              c_ack,
    input  logic [31:0]       c_rdata
);

    localparam logic [SAW-1:0] A_DATA = SAW'(WIN_BASE);
    localparam logic [SAW-1:0] A_CTRL = SAW'(WIN_BASE + 1);

    logic          sel_data, sel_ctrl, launch;
    logic          busy, done_flag, capture;
    logic [DW-1:0] data_q, ctrl_q, ctrl_view;

    assign sel_data = (h_addr == A_DATA);
    assign sel_ctrl = (h_addr == A_CTRL);
    assign launch   = h_wr && sel_ctrl && h_be[LANES-1];

    cfgwin_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (h_wr && !busy),
        .sel_data (sel_data),
        .sel_ctrl (sel_ctrl),
        .be       (h_be),
        .wdata    (h_wdata),
        .cap_en   (capture),
        .cap_data (c_rdata),
        .data_q   (data_q),
        .ctrl_q   (ctrl_q)
    );

    cfgwin_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .warm    (warm_rst),
        .ack     (c_ack),
        .dir_we  (ctrl_q[B_DIR]),
        .busy    (busy),
        .done    (done_flag),
        .req     (c_req),
        .capture (capture)
    );

    assign c_we     = ctrl_q[B_DIR];
    assign c_addr   = ctrl_q[DA_HI:DA_LO];
    assign c_vf     = ctrl_q[VF_HI:VF_LO];
    assign c_vf_en  = ctrl_q[B_VFEN];
    assign c_pf     = ctrl_q[PF_HI:PF_LO];
    assign c_shadow = ctrl_q[B_SHADOW];
    assign c_vsec   = ctrl_q[B_VSEC];
    assign c_wdata  = data_q;

    always_comb begin
        ctrl_view         = ctrl_q;
        ctrl_view[B_DONE] = done_flag;
        ctrl_view[B_WARM] = !warm_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= '0;
        end else if (h_rd) begin
            if (sel_data)      h_rdata <= data_q;
            else if (sel_ctrl) h_rdata <= ctrl_view;
            else               h_rdata <= '0;
        end
    end

    assert_launch_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy && !warm_rst) |=> !done_flag);

    assert_done_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack) |=> (done_flag && !c_req));

    assert_ack_only_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_ack |-> c_req);

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack && !c_we) |=> (c_wdata == $past(c_rdata)));

    assert_write_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack && c_we) |=> $stable(c_wdata));

    assert_fields_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ack && !warm_rst) |=>
            ($stable(c_addr) && $stable(c_we) && $stable(c_wdata) &&
             $stable(c_pf) && $stable(c_vf) && $stable(c_vf_en)));

    assert_warm_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> done_flag);

endmodule

// File: tb/cfgwin_bridge_test.sv
module cfgwin_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic [2:0]  h_addr = '0;
    logic [3:0]  h_be = '0;
    logic        h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic        h_rd = 1'b0;
    logic [31:0] h_rdata;
    logic        c_req, c_we, c_vf_en, c_shadow, c_vsec;
    logic [9:0]  c_addr;
    logic [10:0] c_vf;
    logic [2:0]  c_pf;
    logic [31:0] c_wdata;
    logic        c_ack = 1'b0;
    logic [31:0] c_rdata = '0;

    int checks = 0;
    int failures = 0;
    int hs_cnt = 0;

    localparam logic [2:0] AD = 3'd2;
    localparam logic [2:0] AC = 3'd3;

    cfgwin_bridge #(.SAW(3), .WIN_BASE(2)) uut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .h_addr(h_addr), .h_be(h_be), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rd(h_rd), .h_rdata(h_rdata),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_vf(c_vf),
        .c_vf_en(c_vf_en), .c_pf(c_pf), .c_shadow(c_shadow), .c_vsec(c_vsec),
        .c_wdata(c_wdata), .c_ack(c_ack), .c_rdata(c_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (c_req && c_ack) hs_cnt++;

    localparam int NV = 6;
    localparam logic [2:0]  V_ADDR [NV] = '{AD, AD, AD, AC, 3'd5, AC};
    localparam logic [3:0]  V_BE   [NV] = '{4'hF, 4'h1, 4'h6, 4'h7, 4'hF, 4'h3};
    localparam logic [31:0] V_WD   [NV] = '{32'h11223344, 32'hAABBCCDD, 32'h00EEFF00,
                                           32'h00003FFF, 32'hFFFFFFFF, 32'h00000000};
    localparam logic [31:0] V_EXP  [NV] = '{32'h11223344, 32'h112233DD, 32'h11EEFFDD,
                                           32'hA0003FFF, 32'h00000000, 32'hA0000000};
    localparam string       V_REQ  [NV] = '{"R1", "R9", "R9", "R8", "R1", "R9"};

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        h_addr = a; h_be = be; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; h_be = '0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        h_addr = a; h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0;
        d = h_rdata;
    endtask

    task automatic pulse_ack(input logic [31:0] rd);
        c_ack = 1'b1; c_rdata = rd;
        @(negedge clk);
        c_ack = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int          hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        hread(AC, rv); chk("R10", rv, 32'hA0000000);
        hread(AD, rv); chk("R10", rv, 32'h0);
        chk("R10", {31'b0, c_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            hwrite(V_ADDR[i], V_BE[i], V_WD[i]);
            hread(V_ADDR[i], rv);
            chk(V_REQ[i], rv, V_EXP[i]);
        end

        // Write transfer: R2, R3, R6, R4, R5
        hwrite(AD, 4'hF, 32'hCAFEF00D);
        hwrite(AC, 4'h7, 32'h008F4A95);
        hs0 = hs_cnt;
        hwrite(AC, 4'h8, 32'hF6000000);
        chk("R3", {31'b0, c_req}, 32'h1);
        chk("R2", {31'b0, c_we}, 32'h1);
        chk("R2", {22'b0, c_addr}, 32'h2A5);
        chk("R2", {21'b0, c_vf}, 32'h5A3);
        chk("R2", {29'b0, c_pf}, 32'h5);
        chk("R2", {29'b0, c_vf_en, c_shadow, c_vsec}, 32'h5);
        chk("R2", c_wdata, 32'hCAFEF00D);
        hread(AC, rv); chk("R3", rv, 32'h768F4A95);
        hwrite(AD, 4'hF, 32'hFFFFFFFF);
        hwrite(AC, 4'hF, 32'h40000000);
        chk("R6", {22'b0, c_addr}, 32'h2A5);
        chk("R6", c_wdata, 32'hCAFEF00D);
        chk("R4", {31'b0, c_req}, 32'h1);
        pulse_ack(32'h12345678);
        chk("R4", {31'b0, c_req}, 32'h0);
        hread(AC, rv); chk("R4", rv & 32'h80000000, 32'h80000000);
        chk("R3", 32'(hs_cnt - hs0), 32'd1);
        hread(AD, rv); chk("R5", rv, 32'hCAFEF00D);

        // Read transfer: R5
        hwrite(AC, 4'h7, 32'h00000044);
        hwrite(AC, 4'h8, 32'h00000000);
        chk("R2", {31'b0, c_we}, 32'h0);
        chk("R2", {22'b0, c_addr}, 32'h011);
        hread(AC, rv); chk("R3", rv & 32'h80000000, 32'h0);
        pulse_ack(32'hDEADBEEF);
        hread(AD, rv); chk("R5", rv, 32'hDEADBEEF);
        hread(AC, rv); chk("R4", rv & 32'h80000000, 32'h80000000);

        // Warm reset: R7, R8
        hwrite(AC, 4'h8, 32'h40000000);
        chk("R7", {31'b0, c_req}, 32'h1);
        hs0 = hs_cnt;
        warm_rst = 1'b1;
        #1;
        chk("R7", {31'b0, c_req}, 32'h0);
        @(negedge clk);
        hread(AC, rv); chk("R7", rv & 32'hE0000000, 32'hC0000000);
        hwrite(AC, 4'h8, 32'h60000000);
        hread(AC, rv); chk("R8", rv & 32'hE0000000, 32'hC0000000);
        chk("R7", {31'b0, c_req}, 32'h0);
        warm_rst = 1'b0;
        @(negedge clk);
        chk("R7", {31'b0, c_req}, 32'h0);
        hread(AC, rv); chk("R7", rv & 32'hE0000000, 32'hE0000000);
        chk("R7", 32'(hs_cnt - hs0), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule